// File: doc/BRIEF.md
# Execution-Enable Set/Clear Unit

This block carries out four atomic operations on two execution-enable bits. One bit is the thread-enable bit, held in a per-virtual-processor control register. The other is the virtual-processor-enable bit, held in a processor-wide control register. The block takes one instruction word with a valid strobe. It returns the full prior contents of the targeted register for write-back to the destination register. On the same clock edge it writes the selected bit with the instruction's set/clear value. Both control registers are 32-bit registers inside the block. Their enable bits are also driven out as levels so that the scheduling logic can act on them.

A small state machine has three states. `ST_IDLE` means nothing is pending. `ST_DONE` means a completed operation is being presented. `ST_FAULT` means an exception is being presented. The transitions are:

- IDLE/DONE/FAULT → DONE on a legal, permitted instruction.
- IDLE/DONE/FAULT → FAULT on a matching instruction that must trap.
- Any state → IDLE when no matching instruction arrives.

Every response is registered and appears one cycle after the strobe. Back-to-back instructions are accepted in every cycle. The read and the write of one instruction happen on a single edge, so no other event can fall between them.

Top module: `mt_enable_ctl`

## Requirements
- R1: Instruction fields are: bits 31:26 = 010000, bits 25:21 = 01011, rt in bits 20:16, target-A in bits 15:11, target-B in bits 10:6, set/clear in bit 5, bits 4:3 = 00, bits 2:0 = 001. A strobed word whose bits 31:21 do not match gives no response, raises no exception and changes no state.
- R2: Target-A = 00001 with target-B = 01111 selects the thread-enable register. Its full prior 32-bit value is returned. Bit THR_BIT (15) then takes the set/clear value and all other bits keep their values. `thr_en` shows that bit.
- R3: Target-A = 00000 with target-B = 00000 selects the processor-wide register, and its full prior value is returned. Bit VP_BIT (0) takes the set/clear value only when `master_priv` is 1. Otherwise the bit is unchanged. `vp_en` shows that bit.
- R4: A response (`rsp_valid`, `exc_cu` or `exc_ri`) is a one-cycle pulse in the cycle after the strobe, and at most one of the three is high at a time. `rsp_rt` carries the instruction's rt field.
- R5: When rt is 0, `rsp_valid` is still raised and the bit update still happens, but `rsp_we` stays 0. For rt other than 0, `rsp_we` equals `rsp_valid`.
- R6: With `mt_present`=1 and `cp0_usable`=0, a matching instruction raises `exc_cu` and changes neither register.
- R7: With `mt_present`=0, a matching instruction raises `exc_ri` and changes neither register, whatever the value of `cp0_usable`.
- R8: A matching, usable instruction raises `exc_ri` and changes nothing if its target pair is not one of the two legal pairs, or if bits 4:3 are not 00, or if bits 2:0 are not 001.
- R9: Instructions on consecutive cycles are each applied whole. The second instruction returns the value the first one left.
- R10: After reset the registers hold THR_RST (0x00000A01) and VP_RST (0x00000002), and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 32 | Instruction word |
| cp0_usable | input | 1 | Control-coprocessor access enabled |
| mt_present | input | 1 | Multithreading extension configured in |
| master_priv | input | 1 | Issuing context holds master privilege |
| rsp_valid | output | 1 | Completed operation, data valid |
| rsp_we | output | 1 | Destination write enable (rt not 0) |
| rsp_rt | output | 5 | Destination register index |
| rsp_data | output | 32 | Prior value of the targeted register |
| exc_cu | output | 1 | Coprocessor-unusable exception |
| exc_ri | output | 1 | Reserved-instruction exception |
| thr_en | output | 1 | Current thread-enable bit |
| vp_en | output | 1 | Current virtual-processor-enable bit |

## Verification
A corrupted control register shows in two places. It reaches `thr_en` or `vp_en` in the cycle after the faulty commit. It also reaches `rsp_data` on the next instruction that targets the same register, which in back-to-back traffic is one cycle later. A wrong state or exception decision shows as a missing, extra or doubled pulse among `rsp_valid`, `exc_cu` and `exc_ri` in the cycle after the strobe. A sweep over every target kind, set/clear value, rt choice and permission combination, with results compared against a running model, exposes either kind of error within a cycle or two of its cause.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_IDX_W = 5;

    localparam logic [5:0] MAJOR_OP = 6'b010000;
    localparam logic [4:0] MINOR_OP = 5'b01011;
    localparam logic [2:0] TAIL_CODE = 3'b001;

    localparam logic [4:0] THR_SEL_A = 5'd1;
    localparam logic [4:0] THR_SEL_B = 5'd15;
    localparam logic [4:0] VP_SEL_A = 5'd0;
    localparam logic [4:0] VP_SEL_B = 5'd0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } mtc_state_e;

    typedef enum logic [1:0] {
        TGT_THREAD = 2'd0,
        TGT_VPROC  = 2'd1,
        TGT_NONE   = 2'd2
    } mtc_tgt_e;

endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
    import mtc_pkg::*;
(
    input  logic [WORD_W-1:0]    word,
    output logic                 is_family,
    output mtc_tgt_e             tgt,
    output logic                 sc,
    output logic [REG_IDX_W-1:0] rt
);
    logic [4:0] sel_a;
    logic [4:0] sel_b;
    logic       tail_ok;

    always_comb begin
        is_family = (word[31:26] == MAJOR_OP) && (word[25:21] == MINOR_OP);
        rt        = word[20:16];
        sel_a     = word[15:11];
        sel_b     = word[10:6];
        sc        = word[5];
        tail_ok   = (word[4:3] == 2'b00) && (word[2:0] == TAIL_CODE);
        tgt       = TGT_NONE;
        if (tail_ok) begin
            if (sel_a == THR_SEL_A && sel_b == THR_SEL_B) begin
                tgt = TGT_THREAD;
            end else if (sel_a == VP_SEL_A && sel_b == VP_SEL_B) begin
                tgt = TGT_VPROC;
            end
        end
    end
endmodule

// File: rtl/mtc_ctrl_regs.sv
module mtc_ctrl_regs #(
    parameter int unsigned W       = 32,
    parameter int unsigned THR_BIT = 15,
    parameter int unsigned VP_BIT  = 0,
    parameter logic [W-1:0] THR_RST = 32'h0000_0A01,
    parameter logic [W-1:0] VP_RST  = 32'h0000_0002
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         thr_we,
    input  logic         vp_we,
    input  logic         sc,
    output logic [W-1:0] thr_q,
    output logic [W-1:0] vp_q
);
    localparam int unsigned NREG = 2;
    logic [W-1:0] reg_q [NREG];
    logic [NREG-1:0] we_v;

    assign we_v  = {vp_we, thr_we};
    assign thr_q = reg_q[0];
    assign vp_q  = reg_q[1];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam int unsigned POS = (g == 0) ? THR_BIT : VP_BIT;
        localparam logic [W-1:0] RST = (g == 0) ? THR_RST : VP_RST;
        localparam logic [W-1:0] KEEP = ~(W'(1) << POS);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[g] <= RST;
            end else if (we_v[g]) begin
                reg_q[g][POS] <= sc;
            end
        end

        // R2: only the enable bit may ever move
        assert_other_bits_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(reg_q[g] & KEEP));
    end
endmodule

// File: rtl/mt_enable_ctl.sv
module mt_enable_ctl
    import mtc_pkg::*;
#(
    parameter int unsigned THR_BIT = 15,
    parameter int unsigned VP_BIT  = 0,
    parameter logic [WORD_W-1:0] THR_RST = 32'h0000_0A01,
    parameter logic [WORD_W-1:0] VP_RST  = 32'h0000_0002
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [WORD_W-1:0]    instr_word,
    input  logic                 cp0_usable,
    input  logic                 mt_present,
    input  logic                 master_priv,
    output logic                 rsp_valid,
    output logic                 rsp_we,
    output logic [REG_IDX_W-1:0] rsp_rt,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 exc_cu,
    output logic                 exc_ri,
    output logic                 thr_en,
    output logic                 vp_en
);
    logic                 is_family;
    mtc_tgt_e             tgt;
    logic                 sc;
    logic [REG_IDX_W-1:0] rt;
    logic [WORD_W-1:0]    thr_q;
    logic [WORD_W-1:0]    vp_q;

    logic       hit;
    logic       commit;
    logic       raise_cu;
    logic       raise_ri;
    logic       thr_we;
    logic       vp_we;
    mtc_state_e state_q;
    mtc_state_e state_d;
    logic       cu_q;
    logic       ri_q;

    mtc_decode u_decode (
        .word      (instr_word),
        .is_family (is_family),
        .tgt       (tgt),
        .sc        (sc),
        .rt        (rt)
    );

    mtc_ctrl_regs #(
        .W       (WORD_W),
        .THR_BIT (THR_BIT),
        .VP_BIT  (VP_BIT),
        .THR_RST (THR_RST),
        .VP_RST  (VP_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .thr_we (thr_we),
        .vp_we  (vp_we),
        .sc     (sc),
        .thr_q  (thr_q),
        .vp_q   (vp_q)
    );

    always_comb begin
        hit      = instr_valid && is_family;
        raise_ri = hit && (!mt_present || (cp0_usable && tgt == TGT_NONE));
        raise_cu = hit && mt_present && !cp0_usable;
        commit   = hit && mt_present && cp0_usable && (tgt != TGT_NONE);
        thr_we   = commit && (tgt == TGT_THREAD);
        vp_we    = commit && (tgt == TGT_VPROC) && master_priv;
        unique case (1'b1)
            commit:              state_d = ST_DONE;
            raise_ri | raise_cu: state_d = ST_FAULT;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cu_q     <= 1'b0;
            ri_q     <= 1'b0;
            rsp_rt   <= '0;
            rsp_data <= '0;
        end else begin
            cu_q <= raise_cu;
            ri_q <= raise_ri;
            if (commit) begin
                rsp_rt   <= rt;
                rsp_data <= (tgt == TGT_VPROC) ? vp_q : thr_q;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        exc_cu    = 1'b0;
        exc_ri    = 1'b0;
        unique case (state_q)
            ST_DONE:  rsp_valid = 1'b1;
            ST_FAULT: begin
                exc_cu = cu_q;
                exc_ri = ri_q;
            end
            default:  ;
        endcase
        rsp_we = rsp_valid && (rsp_rt != '0);
        thr_en = thr_q[THR_BIT];
        vp_en  = vp_q[VP_BIT];
    end

    assert_one_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, exc_cu, exc_ri}));

    assert_pulse_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && (rsp_valid || exc_cu || exc_ri)) |=> !(rsp_valid || exc_cu || exc_ri));

    assert_foreign_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid || !is_family) |=> (!rsp_valid && !exc_cu && !exc_ri));

    assert_thread_bit_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> (thr_en == $past(sc)));

    assert_nonmaster_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && tgt == TGT_VPROC && !master_priv) |=> $stable(vp_en));

    // R6, R7 and R8: a trapped instruction leaves both registers untouched
    assert_fault_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_cu || exc_ri) |-> ($stable(thr_q) && $stable(vp_q)));

    assert_fault_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> (exc_cu ^ exc_ri));

endmodule

// File: tb/mt_enable_ctl_tb.sv
module mt_enable_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        cp0_usable = 1'b0;
    logic        mt_present = 1'b0;
    logic        master_priv = 1'b0;
    logic        rsp_valid, rsp_we, exc_cu, exc_ri, thr_en, vp_en;
    logic [4:0]  rsp_rt;
    logic [31:0] rsp_data;

    int total = 0;
    int bad = 0;
    logic [31:0] m_thr = 32'h0000_0A01;
    logic [31:0] m_vp  = 32'h0000_0002;

    always #2 clk = ~clk;

    mt_enable_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .cp0_usable(cp0_usable), .mt_present(mt_present), .master_priv(master_priv),
        .rsp_valid(rsp_valid), .rsp_we(rsp_we), .rsp_rt(rsp_rt), .rsp_data(rsp_data),
        .exc_cu(exc_cu), .exc_ri(exc_ri), .thr_en(thr_en), .vp_en(vp_en)
    );

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] a,
                                       input logic [4:0] b, input logic s,
                                       input logic [1:0] mid, input logic [2:0] tl);
        return {6'b010000, 5'b01011, rt, a, b, s, mid, tl};
    endfunction

    // Drives one cycle at a negedge, checks the registered response at the next negedge.
    task automatic step(input logic vld, input logic [31:0] w, input logic cp0,
                        input logic mt, input logic mst);
        logic fam, legal, is_thr, is_vp;
        logic e_v, e_cu, e_ri, e_we;
        logic [31:0] e_d;
        string tag;
        fam    = vld && (w[31:26] == 6'b010000) && (w[25:21] == 5'b01011);
        is_thr = (w[15:11] == 5'd1) && (w[10:6] == 5'd15);
        is_vp  = (w[15:11] == 5'd0) && (w[10:6] == 5'd0);
        legal  = (w[4:3] == 2'b00) && (w[2:0] == 3'b001) && (is_thr || is_vp);
        e_v = 0; e_cu = 0; e_ri = 0; e_d = '0;
        tag = vld ? "R1" : "R4";
        if (fam) begin
            if (!mt) begin
                e_ri = 1; tag = "R7";
            end else if (!cp0) begin
                e_cu = 1; tag = "R6";
            end else if (!legal) begin
                e_ri = 1; tag = "R8";
            end else begin
                e_v = 1;
                if (is_thr) begin
                    e_d = m_thr; m_thr[15] = w[5]; tag = "R2";
                end else begin
                    e_d = m_vp; tag = "R3";
                    if (mst) m_vp[0] = w[5];
                end
                if (w[20:16] == 5'd0) tag = "R5";
            end
        end
        e_we = e_v && (w[20:16] != 5'd0);
        instr_valid = vld; instr_word = w; cp0_usable = cp0; mt_present = mt; master_priv = mst;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        total++;
        if (rsp_valid !== e_v || exc_cu !== e_cu || exc_ri !== e_ri || rsp_we !== e_we ||
            thr_en !== m_thr[15] || vp_en !== m_vp[0] ||
            (e_v && (rsp_data !== e_d || rsp_rt !== w[20:16]))) begin
            bad++;
            $display("FAIL %s: got v=%b cu=%b ri=%b we=%b rt=%0d d=%h te=%b ve=%b exp v=%b cu=%b ri=%b we=%b rt=%0d d=%h te=%b ve=%b",
                     tag, rsp_valid, exc_cu, exc_ri, rsp_we, rsp_rt, rsp_data, thr_en, vp_en,
                     e_v, e_cu, e_ri, e_we, w[20:16], e_d, m_thr[15], m_vp[0]);
        end
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: got hang exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state at the ports
        total++;
        if (rsp_valid !== 0 || exc_cu !== 0 || exc_ri !== 0 || rsp_we !== 0 ||
            thr_en !== 0 || vp_en !== 0) begin
            bad++;
            $display("FAIL R10: got v=%b cu=%b ri=%b te=%b ve=%b exp all 0",
                     rsp_valid, exc_cu, exc_ri, thr_en, vp_en);
        end
        rst_n = 1'b1;
        // R10: full reset contents read back through one operation each
        step(1, mk(5'd3, 5'd1, 5'd15, 1'b0, 2'b00, 3'b001), 1, 1, 1);
        step(1, mk(5'd3, 5'd0, 5'd0, 1'b0, 2'b00, 3'b001), 1, 1, 1);
        // R1: foreign words are ignored
        step(1, 32'h0000_0000, 1, 1, 1);
        step(1, mk(5'd2, 5'd1, 5'd15, 1'b1, 2'b00, 3'b001) ^ 32'h0400_0000, 1, 1, 1);
        step(1, mk(5'd2, 5'd0, 5'd0, 1'b1, 2'b00, 3'b001) ^ 32'h0020_0000, 1, 1, 1);
        step(0, mk(5'd2, 5'd1, 5'd15, 1'b1, 2'b00, 3'b001), 1, 1, 1);
        // Sweep: target kinds x set/clear x permissions x rt; consecutive calls are
        // back-to-back (R9), idle cycles interleaved after some to check pulse drop (R4)
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 5; k++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int r = 0; r < 2; r++) begin
                        logic [31:0] w;
                        logic [4:0] rtv;
                        rtv = (r == 0) ? 5'd0 : 5'd9;
                        case (k)
                            0: w = mk(rtv, 5'd1, 5'd15, s[0], 2'b00, 3'b001);
                            1: w = mk(rtv, 5'd0, 5'd0, s[0], 2'b00, 3'b001);
                            2: w = mk(rtv, 5'd1, 5'd0, s[0], 2'b00, 3'b001);
                            3: w = mk(rtv, 5'd0, 5'd0, s[0], 2'b10, 3'b001);
                            default: w = mk(rtv, 5'd1, 5'd15, s[0], 2'b00, 3'b011);
                        endcase
                        step(1, w, c[0], c[1], c[2]);
                        // R9: flip the same bit back in the next cycle
                        if (k < 2) step(1, w ^ 32'h20, c[0], c[1], c[2]);
                        if (r == 1) step(0, '0, 1, 1, 1);
                    end
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule